// File: doc/BRIEF.md
# Paged I2C Register Target

This block is an I2C target that gives a bus master access to a register space wider than one byte of address. Every internal register has a 16-bit index: the upper byte is a page number held inside the block, the lower byte is the offset the master sends on the bus. One offset, 0xFF, is reserved in every page as the page selector. A byte written there replaces the current page. Every other offset goes to the register at that offset in the current page.

The master writes a register with a short transaction: the target address with the write bit, an offset byte, one or more data bytes, then STOP. Extra data bytes land at consecutive offsets, which is how 16-bit values are stored (high byte first). To read, the master writes the offset byte, issues a repeated START with the read bit, and clocks out as many consecutive bytes as it wants. It ends the read with a NACK. The SDA line is open-drain: the block only ever pulls it low.

The back end holds a parameterised list of populated pages. Pages that are not in the list discard writes and read as zero.

Top module: `paged_i2c_regs`

## Requirements
- R1: A START followed by the 7-bit address `DEV_ADDR` and a R/W bit (0 = write, 1 = read, the LSB of the first byte) is acknowledged. Any other address gets no acknowledge, and the block ignores the bus until the next START.
- R2: In a write transaction, the first byte after the address is taken as the offset pointer, and the block acknowledges it.
- R3: Each later write byte at an offset other than 0xFF is stored at index {page, offset} and acknowledged.
- R4: A write byte at offset 0xFF becomes the current page for all later accesses, including those in the same transaction.
- R5: Consecutive write bytes go to consecutive offsets. A 16-bit value sent high byte first puts its low byte at offset+1.
- R6: A read transaction returns the byte at the pointer. The pointer advances after every byte the master acknowledges. A master NACK ends the transfer with SDA released.
- R7: A read of offset 0xFF returns the current page number.
- R8: The offset pointer wraps from 0xFF to 0x00 and never carries into the page.
- R9: Pages outside `PAGE_LIST` ignore writes and read as 0x00.
- R10: After reset, the current page is 0x00 and every populated register reads 0x00.
- R11: The block only pulls SDA low. It releases SDA at reset and after every STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the I2C lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
A wrong page register shows up on the next read of offset 0xFF, and on every later access as data landing in or coming from another page. A reference model catches that within the first byte read after the error. A wrong offset pointer shows up as a byte out of sequence within one byte time of a block read, or as a value missing at offset+1 after a 16-bit write. A faulty bit-level state is visible at the ninth clock of a byte: the acknowledge slot is wrong, SDA stays held after a NACK or STOP, or a read byte is shifted by one bit.

// File: rtl/pgi2c_pkg.sv
package pgi2c_pkg;
  localparam logic [7:0] PAGE_SEL_OFF = 8'hFF;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ADDR_ACK,
    PH_RX,
    PH_RX_ACK,
    PH_TX,
    PH_TX_ACK
  } phase_e;
endpackage

// File: rtl/pgi2c_bit_target.sv
module pgi2c_bit_target
  import pgi2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h70
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       wr_stb,
  output logic       wr_first,
  output logic [7:0] wr_byte,
  output logic       rd_stb,
  input  logic [7:0] rd_byte,
  output logic       stop_evt
);
  logic [2:0] scl_q, sda_q;
  phase_e     ph_q, ph_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d;
  logic       rw_q, rw_d, first_q, first_d, oe_q, oe_d, nack_q, nack_d;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign scl_s     = scl_q[1];
  assign sda_s     = sda_q[1];
  assign scl_rise  = scl_q[1] & ~scl_q[2];
  assign scl_fall  = ~scl_q[1] & scl_q[2];
  assign start_evt = scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
  assign stop_evt  = scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    rw_d    = rw_q;
    first_d = first_q;
    oe_d    = oe_q;
    nack_d  = nack_q;
    wr_stb  = 1'b0;
    rd_stb  = 1'b0;
    if (start_evt) begin
      ph_d    = PH_ADDR;
      cnt_d   = 4'd0;
      oe_d    = 1'b0;
      first_d = 1'b1;
    end else if (stop_evt) begin
      ph_d = PH_IDLE;
      oe_d = 1'b0;
    end else begin
      unique case (ph_q)
        PH_ADDR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            cnt_d = 4'd0;
            if (sh_q[7:1] == DEV_ADDR) begin
              rw_d = sh_q[0];
              oe_d = 1'b1;
              ph_d = PH_ADDR_ACK;
            end else begin
              ph_d = PH_IDLE;
            end
          end
        end
        PH_ADDR_ACK, PH_RX_ACK: begin
          if (scl_rise) cnt_d = cnt_q + 4'd1;
          else if (scl_fall && cnt_q == 4'd1) begin
            cnt_d = 4'd0;
            if (ph_q == PH_ADDR_ACK && rw_q) begin
              rd_stb = 1'b1;
              sh_d   = rd_byte;
              oe_d   = ~rd_byte[7];
              ph_d   = PH_TX;
            end else begin
              oe_d = 1'b0;
              ph_d = PH_RX;
            end
          end
        end
        PH_RX: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            wr_stb  = 1'b1;
            first_d = 1'b0;
            oe_d    = 1'b1;
            cnt_d   = 4'd0;
            ph_d    = PH_RX_ACK;
          end
        end
        PH_TX: begin
          if (scl_rise) cnt_d = cnt_q + 4'd1;
          else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              oe_d  = 1'b0;
              cnt_d = 4'd0;
              ph_d  = PH_TX_ACK;
            end else begin
              sh_d = {sh_q[6:0], 1'b0};
              oe_d = ~sh_q[6];
            end
          end
        end
        PH_TX_ACK: begin
          if (scl_rise) begin
            nack_d = sda_s;
            cnt_d  = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd1) begin
            cnt_d = 4'd0;
            if (!nack_q) begin
              rd_stb = 1'b1;
              sh_d   = rd_byte;
              oe_d   = ~rd_byte[7];
              ph_d   = PH_TX;
            end else begin
              ph_d = PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= 4'd0;
      sh_q    <= 8'd0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      oe_q    <= 1'b0;
      nack_q  <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      rw_q    <= rw_d;
      first_q <= first_d;
      oe_q    <= oe_d;
      nack_q  <= nack_d;
    end
  end

  assign sda_oe   = oe_q;
  assign wr_byte  = sh_q;
  assign wr_first = first_q;
endmodule

// File: rtl/pgi2c_page_store.sv
module pgi2c_page_store #(
  parameter int                    NUM_PAGES = 6,
  parameter logic [NUM_PAGES*8-1:0] PAGE_LIST = {8'h12, 8'h11, 8'h10, 8'h09, 8'h02, 8'h00}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [15:0] waddr,
  input  logic [7:0]  wdata,
  input  logic [15:0] raddr,
  output logic [7:0]  rdata
);
  localparam int DEPTH = NUM_PAGES * 256;
  localparam int SW    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;

  logic [7:0]           mem_q [DEPTH];
  logic [NUM_PAGES-1:0] w_match, r_match;
  logic [SW-1:0]        w_slot, r_slot;
  logic                 w_hit, r_hit;

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
    assign w_match[g] = (waddr[15:8] == PAGE_LIST[g*8 +: 8]);
    assign r_match[g] = (raddr[15:8] == PAGE_LIST[g*8 +: 8]);
  end

  always_comb begin
    w_slot = '0;
    r_slot = '0;
    for (int p = 0; p < NUM_PAGES; p++) begin
      if (w_match[p]) w_slot = SW'(p);
      if (r_match[p]) r_slot = SW'(p);
    end
  end

  assign w_hit = |w_match;
  assign r_hit = |r_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'd0;
    end else if (we && w_hit) begin
      mem_q[{w_slot, waddr[7:0]}] <= wdata;
    end
  end

  assign rdata = r_hit ? mem_q[{r_slot, raddr[7:0]}] : 8'd0;
endmodule

// File: rtl/paged_i2c_regs.sv
module paged_i2c_regs
  import pgi2c_pkg::*;
#(
  parameter logic [6:0]             DEV_ADDR  = 7'h70,
  parameter int                     NUM_PAGES = 6,
  parameter logic [NUM_PAGES*8-1:0] PAGE_LIST = {8'h12, 8'h11, 8'h10, 8'h09, 8'h02, 8'h00}
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  logic       wr_stb, wr_first, rd_stb, stop_evt;
  logic [7:0] wr_byte, rd_byte, store_rdata;
  logic [7:0] page_q, page_d, ptr_q, ptr_d;
  logic       ptr_en, page_en, store_we;

  pgi2c_bit_target #(.DEV_ADDR(DEV_ADDR)) u_bit (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .sda_oe  (sda_oe),
    .wr_stb  (wr_stb),
    .wr_first(wr_first),
    .wr_byte (wr_byte),
    .rd_stb  (rd_stb),
    .rd_byte (rd_byte),
    .stop_evt(stop_evt)
  );

  always_comb begin
    ptr_en   = wr_stb | rd_stb;
    ptr_d    = (wr_stb && wr_first) ? wr_byte : ptr_q + 8'd1;
    page_en  = wr_stb && !wr_first && (ptr_q == PAGE_SEL_OFF);
    page_d   = wr_byte;
    store_we = wr_stb && !wr_first && (ptr_q != PAGE_SEL_OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= 8'd0;
      ptr_q  <= 8'd0;
    end else begin
      if (page_en) page_q <= page_d;
      if (ptr_en)  ptr_q  <= ptr_d;
    end
  end

  pgi2c_page_store #(.NUM_PAGES(NUM_PAGES), .PAGE_LIST(PAGE_LIST)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (store_we),
    .waddr({page_q, ptr_q}),
    .wdata(wr_byte),
    .raddr({page_q, ptr_q}),
    .rdata(store_rdata)
  );

  assign rd_byte = (ptr_q == PAGE_SEL_OFF) ? page_q : store_rdata;
endmodule

// File: rtl/paged_i2c_regs_chk.sv
module paged_i2c_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic [7:0] page_q,
  input logic [7:0] ptr_q,
  input logic       wr_stb,
  input logic       wr_first,
  input logic [7:0] wr_byte,
  input logic       rd_stb,
  input logic       stop_evt
);
  // R2: offset byte loads the pointer
  assert_offset_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_first) |=> (ptr_q == $past(wr_byte)));

  // R6 / R8: every read byte advances the pointer modulo 256
  assert_read_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (ptr_q == $past(ptr_q) + 8'd1));

  // R4: page changes only on a data write at the selector offset
  assert_page_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && !wr_first && ptr_q == 8'hFF) |=> $stable(page_q));

  // R11: SDA is released after STOP
  assert_release_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // R6: a byte is never both received and sent in one cycle
  assert_dir_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && rd_stb));
endmodule

bind paged_i2c_regs paged_i2c_regs_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sda_oe  (sda_oe),
  .page_q  (page_q),
  .ptr_q   (ptr_q),
  .wr_stb  (wr_stb),
  .wr_first(wr_first),
  .wr_byte (wr_byte),
  .rd_stb  (rd_stb),
  .stop_evt(stop_evt)
);

// File: tb/test_paged_i2c_regs.sv
module test_paged_i2c_regs;
  localparam logic [6:0] ADDR = 7'h70;
  localparam int Q = 8;

  logic clk, rst_n, scl_m, sda_m;
  wire  sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  int total = 0, fails = 0;
  logic [7:0] mdl [int];
  int mpage = 0, mptr = 0;
  logic [7:0] txq[$];

  paged_i2c_regs i_paged_i2c_regs (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit mapped(input int p);
    return p == 8'h00 || p == 8'h02 || p == 8'h09 || p == 8'h10 || p == 8'h11 || p == 8'h12;
  endfunction

  function automatic int model_rd();
    int idx = (mpage << 8) | mptr;
    if (mptr == 8'hFF) return mpage;
    if (!mapped(mpage) || !mdl.exists(idx)) return 0;
    return int'(mdl[idx]);
  endfunction

  task automatic bitx(input logic b, output logic r);
    sda_m = b;  tick(Q);
    scl_m = 1'b1; tick(Q);
    r = sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bitx(d[i], r);
    bitx(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bitx(1'b1, r);
      d[i] = r;
    end
    bitx(~mack, r);
  endtask

  // Write offset then every byte in txq; model follows R2..R5, R8, R9
  task automatic do_write(input logic [7:0] off, input string req);
    logic ack;
    i2c_start();
    send_byte({ADDR, 1'b0}, ack); check({"R1 ", req}, ack, 1);
    send_byte(off, ack);          check({"R2 ", req}, ack, 1);
    mptr = off;
    foreach (txq[k]) begin
      send_byte(txq[k], ack);     check({"R3 ", req}, ack, 1);
      if (mptr == 8'hFF) mpage = txq[k];
      else if (mapped(mpage)) mdl[(mpage << 8) | mptr] = txq[k];
      mptr = (mptr + 1) & 8'hFF;
    end
    i2c_stop();
    check({"R11 ", req}, sda_oe, 0);
    txq.delete();
  endtask

  task automatic do_read(input logic [7:0] off, input int n, input string req);
    logic ack;
    logic [7:0] d;
    i2c_start();
    send_byte({ADDR, 1'b0}, ack); check({"R1 ", req}, ack, 1);
    send_byte(off, ack);          check({"R2 ", req}, ack, 1);
    mptr = off;
    i2c_start();
    send_byte({ADDR, 1'b1}, ack); check({"R1 ", req}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      check({"R6 ", req}, d, model_rd());
      mptr = (mptr + 1) & 8'hFF;
    end
    tick(4);
    check({"R6 nack release ", req}, sda_oe, 0);
    i2c_stop();
    check({"R11 ", req}, sda_oe, 0);
  endtask

  task automatic set_page(input logic [7:0] p);
    txq.push_back(p);
    do_write(8'hFF, "R4 page select");
  endtask

  initial begin
    logic ack;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    tick(5);
    check("R11 reset sda", sda_oe, 0);
    rst_n = 1'b1;
    tick(5);

    do_read(8'h10, 1, "R10 reset reg");
    do_read(8'hFF, 1, "R10 R7 reset page");

    txq.push_back(8'hA5);
    do_write(8'h10, "R3 single");
    do_read(8'h10, 1, "R3 readback");

    txq.push_back(8'h12); txq.push_back(8'h34);
    do_write(8'h20, "R5 16-bit");
    do_read(8'h1F, 4, "R5 R6 block");

    set_page(8'h09);
    txq.push_back(8'h5C);
    do_write(8'h10, "R4 page9 write");
    do_read(8'h10, 1, "R4 page9 read");
    do_read(8'hFF, 1, "R7 page readback");
    set_page(8'h00);
    do_read(8'h10, 1, "R4 page0 intact");

    set_page(8'h02);
    txq.push_back(8'h77);
    do_write(8'hFE, "R8 fe");
    txq.push_back(8'h66);
    do_write(8'h00, "R8 00");
    do_read(8'hFE, 3, "R8 wrap R7");
    check("R8 page after wrap", mpage, 2);

    set_page(8'h05);
    txq.push_back(8'hEE);
    do_write(8'h10, "R9 unmapped write");
    do_read(8'h10, 2, "R9 unmapped read");

    // Foreign address: no ack on address or following bytes
    i2c_start();
    send_byte({7'h21, 1'b0}, ack); check("R1 foreign addr nack", ack, 0);
    send_byte(8'hFF, ack);         check("R1 foreign off nack", ack, 0);
    send_byte(8'h00, ack);         check("R1 foreign data nack", ack, 0);
    i2c_stop();
    do_read(8'hFF, 1, "R1 page untouched");
    set_page(8'h00);
    do_read(8'h10, 1, "R1 reg untouched");

    // Write running through the selector within one transaction (R4)
    txq.push_back(8'h11); txq.push_back(8'h10); txq.push_back(8'h3C);
    do_write(8'hFE, "R4 in-transaction page");
    do_read(8'h00, 1, "R4 in-transaction data");
    do_read(8'hFF, 1, "R4 in-transaction page rd");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule